// File: doc/BRIEF.md
# Fractional Audio Master Clock Generator

This block derives an audio master clock at 256 times the sampling rate from a fixed system clock. It uses a 12-bit phase accumulator that normally advances by a primary increment. On the cycle after the accumulator wraps past 4096, it advances by an alternate increment instead. The alternate step is the primary step plus 4096 minus a chosen modulus N. The extra amount cancels the part of the power-of-two range that is not wanted. As a result, the accumulator behaves as if it wrapped at N, and over the long run it produces exactly I0 wraps for every N input clocks.

Two settings are typical:

- For the 11.2896 MHz (44.1 kHz family) clock: I0 = 1568, N = 3750, alternate increment 1914.
- For the 12.288 MHz (48 kHz family) clock: I0 = 1536, N = 3375, alternate increment 2257.

The accumulator MSB is registered and driven out as the generated clock. The carry is registered and driven out as a one-cycle wrap strobe. Increments are sampled only while the generator is disabled. When the generator is disabled, the accumulator and both outputs are cleared.

A parameter selects what the second increment port carries. In the default variant it carries the alternate increment directly. In the other variant it carries the modulus N, and the alternate increment is derived inside the block.

Top module: `afc_clkgen`

## Requirements
- R1: After reset, with enable low, `aclk_o` and `ovf_o` are both 0.
- R2: On every clock edge with `en_i` high, the accumulator (reset value 0) adds the selected increment modulo 4096. `ovf_o` is 1 in the cycle after an edge whose addition carried out of bit 11, and 0 otherwise.
- R3: The addition that follows a carrying addition uses the alternate increment. Every other addition while enabled, including the first one after enabling, uses the primary increment.
- R4: Once the accumulator has settled, any window of N consecutive enabled cycles contains exactly I0 wrap strobes. This holds for (I0, alternate, N) = (1568, 1914, 3750) and (1536, 2257, 3375).
- R5: `aclk_o` is the registered bit 11 of the new accumulator value. For both settings in R4, the count of its rising edges in an N-cycle window is within one of I0.
- R6: On any edge with `en_i` low, the accumulator, the increment selection, `aclk_o` and `ovf_o` are cleared. They stay cleared while `en_i` stays low.
- R7: The increment registers load from the ports only on edges where `en_i` is low. Changes to the increment ports while enabled have no effect on the outputs.
- R8: With `DERIVE_ALT = 1`, `inc_alt_i` carries the modulus N, and the alternate increment used is I0 + 4096 − N. The outputs are then cycle-identical to the default variant given that alternate increment directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (nominally 27 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; while low, state clears and increments load |
| inc_pri_i | input | ACC_W | Primary increment I0 |
| inc_alt_i | input | ACC_W | Alternate increment, or modulus N when DERIVE_ALT = 1 |
| aclk_o | output | 1 | Generated audio master clock (registered accumulator MSB) |
| ovf_o | output | 1 | One-cycle strobe per accumulator wrap |

## Verification
The hardest condition to reach is the steady state in which the alternate step fires right after a wrap. A window of N cycles there must contain exactly I0 strobes, with no start-up residue. The bench first lets the accumulator run through its start-up transient, which begins from zero below the settled range. It then counts strobes over N consecutive cycles for both clock families. It also compares every cycle of the start of each run against a reference model written from the stepping rule. Increment changes made while running are checked by the same window count, which must still match the old I0. A later disable and re-enable then shows that the new values have loaded.

// File: rtl/afc_pkg.sv
package afc_pkg;

   // Flags produced by one accumulator step
   typedef struct packed {
      logic carry;   // addition overflowed the accumulator width
      logic msb;     // top bit of the new accumulator value
   } afc_step_t;

   // Alternate increment from primary increment and modulus:
   // i0 + 2^w - n, taken modulo 2^w
   function automatic logic [31:0] afc_alt_from_mod(input logic [31:0] i0,
                                                     input logic [31:0] n,
                                                     input int unsigned w);
      logic [31:0] mask;
      mask = (32'h1 << w) - 32'h1;
      return (i0 - n) & mask;
   endfunction

endpackage

// File: rtl/afc_inc_regs.sv
module afc_inc_regs #(
   parameter int unsigned ACC_W      = 12,
   parameter bit          DERIVE_ALT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [ACC_W-1:0] inc_pri_i,
   input  logic [ACC_W-1:0] inc_alt_i,
   output logic [ACC_W-1:0] inc_pri_q,
   output logic [ACC_W-1:0] inc_alt_q
);
   import afc_pkg::*;

   logic [ACC_W-1:0] alt_d;

   generate
      if (DERIVE_ALT) begin : g_derive
         // Port carries the modulus; compute the alternate step
         logic [31:0] alt_wide;
         always_comb begin
            alt_wide = afc_alt_from_mod(32'(inc_pri_i), 32'(inc_alt_i), ACC_W);
            alt_d    = alt_wide[ACC_W-1:0];
         end
      end else begin : g_direct
         assign alt_d = inc_alt_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         inc_pri_q <= '0;
         inc_alt_q <= '0;
      end else if (!en_i) begin
         inc_pri_q <= inc_pri_i;
         inc_alt_q <= alt_d;
      end
   end

   // R7: no reload across an enabled edge
   a_r7_inc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i) |-> ($stable(inc_pri_q) && $stable(inc_alt_q)));

endmodule

// File: rtl/afc_phase_core.sv
module afc_phase_core #(
   parameter int unsigned ACC_W = 12
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   input  logic [ACC_W-1:0]    inc_pri_q,
   input  logic [ACC_W-1:0]    inc_alt_q,
   output logic [ACC_W-1:0]    acc_q,
   output afc_pkg::afc_step_t  step_o
);
   import afc_pkg::*;

   localparam int unsigned SUM_W = ACC_W + 1;

   logic             use_alt_q;
   logic [ACC_W-1:0] inc_sel;
   logic [SUM_W-1:0] sum;

   always_comb begin
      inc_sel      = use_alt_q ? inc_alt_q : inc_pri_q;
      sum          = {1'b0, acc_q} + {1'b0, inc_sel};
      step_o.carry = sum[ACC_W];
      step_o.msb   = sum[ACC_W-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q     <= '0;
         use_alt_q <= 1'b0;
      end else if (!en_i) begin
         acc_q     <= '0;
         use_alt_q <= 1'b0;
      end else begin
         acc_q     <= sum[ACC_W-1:0];
         use_alt_q <= sum[ACC_W];
      end
   end

endmodule

// File: rtl/afc_out_stage.sv
module afc_out_stage (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  afc_pkg::afc_step_t step_i,
   output logic               aclk_o,
   output logic               ovf_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         aclk_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else if (!en_i) begin
         aclk_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         aclk_o <= step_i.msb;
         ovf_o  <= step_i.carry;
      end
   end

endmodule

// File: rtl/afc_clkgen.sv
module afc_clkgen #(
   parameter int unsigned ACC_W      = 12,
   parameter bit          DERIVE_ALT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [ACC_W-1:0] inc_pri_i,
   input  logic [ACC_W-1:0] inc_alt_i,
   output logic             aclk_o,
   output logic             ovf_o
);
   import afc_pkg::*;

   localparam int unsigned MIN_W = 4;
   localparam int unsigned MAX_W = 24;

   generate
      if (ACC_W < MIN_W || ACC_W > MAX_W) begin : g_bad_width
         $error("afc_clkgen: ACC_W out of supported range");
      end
   endgenerate

   logic [ACC_W-1:0] inc_pri_q;
   logic [ACC_W-1:0] inc_alt_q;
   logic [ACC_W-1:0] acc_q;
   afc_step_t        step;

   afc_inc_regs #(.ACC_W(ACC_W), .DERIVE_ALT(DERIVE_ALT)) u_inc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .inc_pri_i (inc_pri_i),
      .inc_alt_i (inc_alt_i),
      .inc_pri_q (inc_pri_q),
      .inc_alt_q (inc_alt_q)
   );

   afc_phase_core #(.ACC_W(ACC_W)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .inc_pri_q (inc_pri_q),
      .inc_alt_q (inc_alt_q),
      .acc_q     (acc_q),
      .step_o    (step)
   );

   afc_out_stage u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .step_i (step),
      .aclk_o (aclk_o),
      .ovf_o  (ovf_o)
   );

   // R2: strobe marks exactly the steps whose result is below the prior value
   a_r2_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i) |-> (ovf_o == (acc_q < $past(acc_q))));

   // R3: step after a wrap uses the alternate increment
   a_r3_alt_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && ovf_o) |=> (acc_q == ACC_W'($past(acc_q) + $past(inc_alt_q))));

   // R3: step without a preceding wrap uses the primary increment
   a_r3_pri_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !ovf_o) |=> (acc_q == ACC_W'($past(acc_q) + $past(inc_pri_q))));

   // R6: disabled edge clears state and outputs
   a_r6_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (acc_q == '0 && !ovf_o && !aclk_o));

endmodule

// File: tb/afc_clkgen_bench.sv
module afc_clkgen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [11:0] inc_pri = '0;
   logic [11:0] inc_alt = '0;
   logic [11:0] modn = '0;
   logic        aclk, ovf, aclk2, ovf2;

   int n_checks = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   afc_clkgen u_afc_clkgen (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en),
      .inc_pri_i(inc_pri), .inc_alt_i(inc_alt),
      .aclk_o(aclk), .ovf_o(ovf)
   );

   afc_clkgen #(.DERIVE_ALT(1'b1)) u_afc_clkgen_drv (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en),
      .inc_pri_i(inc_pri), .inc_alt_i(modn),
      .aclk_o(aclk2), .ovf_o(ovf2)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic load(input int i0, input int i1, input int n);
      @(negedge clk);
      en = 1'b0;
      inc_pri = 12'(i0);
      inc_alt = 12'(i1);
      modn = 12'(n);
      repeat (2) @(negedge clk);
   endtask

   // R1: outputs idle after reset
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(aclk == 1'b0, "R1 aclk after reset", int'(aclk), 0);
      chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
   endtask

   // R2 R3 R5 R8: cycle-by-cycle comparison with a reference stepping model
   task automatic t_trace(input int i0, input int i1, input int n, input int cyc);
      int m_acc = 0;
      int m_sel = 0;
      int bad2 = 0, bad5 = 0, bad8 = 0;
      int first2 = -1;
      load(i0, i1, n);
      en = 1'b1;
      for (int k = 0; k < cyc; k++) begin
         int sum;
         int m_ovf, m_clk;
         @(negedge clk);
         sum   = m_acc + (m_sel != 0 ? i1 : i0);
         m_ovf = (sum >> 12) & 1;
         m_clk = (sum >> 11) & 1;
         m_acc = sum & 12'hfff;
         m_sel = m_ovf;
         if (int'(ovf) != m_ovf) begin bad2++; if (first2 < 0) first2 = k; end
         if (int'(aclk) != m_clk) bad5++;
         if (ovf2 != ovf || aclk2 != aclk) bad8++;
      end
      chk(bad2 == 0, "R2/R3 strobe trace mismatches", bad2, 0);
      chk(bad5 == 0, "R5 aclk trace mismatches", bad5, 0);
      chk(bad8 == 0, "R8 derived variant mismatches", bad8, 0);
   endtask

   // R4 R5: strobe and edge counts over an N-cycle window after settling
   task automatic t_window(input int i0, input int i1, input int n, input bit fresh,
                           input string tag);
      int strobes = 0, rises = 0, strobes2 = 0;
      logic prev;
      if (fresh) begin
         load(i0, i1, n);
         en = 1'b1;
      end
      repeat (40) @(negedge clk);
      prev = aclk;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (ovf) strobes++;
         if (ovf2) strobes2++;
         if (aclk && !prev) rises++;
         prev = aclk;
      end
      chk(strobes == i0, {"R4 strobes in window ", tag}, strobes, i0);
      chk(rises >= i0 - 1 && rises <= i0 + 1, {"R5 aclk rises in window ", tag}, rises, i0);
      chk(strobes2 == i0, {"R8 derived strobes ", tag}, strobes2, i0);
   endtask

   // R6: disable clears outputs and keeps them clear
   task automatic t_disable();
      int seen = 0;
      load(1568, 1914, 3750);
      en = 1'b1;
      repeat (50) @(negedge clk);
      en = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (aclk || ovf) seen++;
      end
      chk(seen == 0, "R6 outputs while disabled", seen, 0);
   endtask

   // R7: increments changed while running have no effect until a disabled edge
   task automatic t_hold();
      load(1568, 1914, 3750);
      en = 1'b1;
      repeat (5) @(negedge clk);
      inc_pri = 12'd1536;
      inc_alt = 12'd2257;
      modn = 12'd3375;
      t_window(1568, 1914, 3750, 1'b0, "R7 after live change");
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      en = 1'b1;
      t_window(1536, 2257, 3375, 1'b0, "R7 after reload");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_trace(1568, 1914, 3750, 200);
      t_trace(1536, 2257, 3375, 200);
      t_window(1568, 1914, 3750, 1'b1, "44k1");
      t_window(1536, 2257, 3375, 1'b1, "48k");
      t_disable();
      t_trace(1536, 2257, 3375, 60);
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule